// File: doc/BRIEF.md
# Multi-Rate CAN Bit Timing Generator

This block places the sample instant of every bit for a CAN receiver whose bit rate changes in the middle of a frame. It keeps three timing settings: nominal, FD data phase and XL data phase. Each setting is a bit width and a sample offset, both counted in system clocks. A setting is derived from the clock rate, the bit rate and the sample-point percentage. For example, at 250 MHz a 1 Mbit/s rate with a 70 % sample point gives a width of 250 and an offset of 175. The block emits a one-clock strobe at the sample instant of each bit, together with the value of the line in that clock. It also reports which rate is in force.

A frame decoder downstream watches each strobe. In the strobe clock it raises a request to change rate. In FD frames the trigger is a recessive rate-switch bit, and the return happens at the CRC delimiter. In XL frames the switch follows the arbitration-to-data high bit, and the return follows the last format-check bit. The bit in which a switch is taken gets a hybrid length: the old sample offset plus the part of a new-rate bit that lies after the new sample offset. Falling edges on the line anchor the sample grid. Such an edge gives a hard synchronisation when the bus is idle and a resynchronisation inside a frame.

The controller has three states. ST_IDLE waits for a start-of-frame edge. ST_LEAD counts from the start of the bit to the sample offset. ST_TAIL counts from the strobe to the end of the bit. The transitions are as follows:
- The hard sync takes ST_IDLE to ST_LEAD.
- The strobe takes ST_LEAD to ST_TAIL.
- The bit end takes ST_TAIL to ST_LEAD.
- A resync re-enters ST_LEAD from either counting state.
- The idle entry takes ST_LEAD to ST_IDLE.

The settings must satisfy offset ≥ GUARD+1 and width − offset ≥ 2.

Top module: `can_rate_timer`

## Requirements
- R1: After reset the block is idle, the rate output is nominal (code 0) and no strobe appears while the line shows no falling edge.
- R2: In idle, a falling edge seen in clock E starts a bit at E. Strobes then follow at E+offset and every nominal width after that.
- R3: Each strobe lasts exactly one clock. The sampled-bit output equals the line value in that clock.
- R4: Rate requests are honoured only in a strobe clock, and the new rate shows from the next clock. Rate codes are nominal 0, FD 1 and XL 2. When several requests are raised together, nominal wins over XL and XL wins over FD.
- R5: In the bit where the rate switches, the clocks from the bit start to the next bit start equal the old offset plus (new width − new offset).
- R6: While the FD or XL rate is in force, strobes are spaced by that rate's width.
- R7: A request for nominal in a strobe clock ends the bit at the strobe plus (nominal width − nominal offset), and nominal spacing resumes.
- R8: Inside a frame, a falling edge in clock X re-anchors the grid so that the next strobe comes at X+offset.
- R9: At most one resynchronisation is taken per bit. A second falling edge before the next regular bit start has no effect on strobe timing.
- R10: A falling edge is ignored when it lands within GUARD clocks (default 2) before the strobe, on the strobe, or within GUARD clocks after it.
- R11: After IDLE_BITS (default 11) consecutive recessive samples, the block returns to idle with nominal rate and stops strobing until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Synchronised bus line, 1 = recessive |
| nom_width_i | input | CNT_W | Nominal bit width in clocks |
| nom_samp_i | input | CNT_W | Nominal sample offset in clocks |
| fd_width_i | input | CNT_W | FD bit width in clocks |
| fd_samp_i | input | CNT_W | FD sample offset in clocks |
| xl_width_i | input | CNT_W | XL bit width in clocks |
| xl_samp_i | input | CNT_W | XL sample offset in clocks |
| req_nom_i | input | 1 | Request nominal rate (taken at a strobe) |
| req_fd_i | input | 1 | Request FD rate (taken at a strobe) |
| req_xl_i | input | 1 | Request XL rate (taken at a strobe) |
| smp_stb_o | output | 1 | One-clock sample strobe |
| smp_bit_o | output | 1 | Line value at the strobe (1 when no strobe) |
| rate_o | output | 2 | Rate in force: 0 nominal, 1 FD, 2 XL |

## Verification
A frame that stays dominant after the start edge shows the bare nominal grid and the idle return when the line goes recessive. Request patterns are used in several forms:
- A request held across non-strobe clocks separates a strobe-qualified capture from a level capture.
- An FD switch followed by a return exposes both hybrid bit lengths.
- Simultaneous requests tell the priority order apart, and this pattern also covers the XL rate.

Rise/fall pulses placed at chosen counter values separate a taken resync, a second edge in the same bit, and edges inside the guard band before and after the strobe.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    typedef enum logic [1:0] {
        RATE_NOM = 2'd0,
        RATE_FD  = 2'd1,
        RATE_XL  = 2'd2
    } rate_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_TAIL = 2'd2
    } bt_state_e;
endpackage

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic fall_o
);
    logic rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx_i;
    end

    assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/cbt_rate_sel.sv
module cbt_rate_sel
    import can_bt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  rate_e            rate_i,
    input  logic [CNT_W-1:0] nom_w_i,
    input  logic [CNT_W-1:0] nom_o_i,
    input  logic [CNT_W-1:0] fd_w_i,
    input  logic [CNT_W-1:0] fd_o_i,
    input  logic [CNT_W-1:0] xl_w_i,
    input  logic [CNT_W-1:0] xl_o_i,
    output logic [CNT_W-1:0] width_o,
    output logic [CNT_W-1:0] off_o
);
    always_comb begin
        unique case (rate_i)
            RATE_FD: begin width_o = fd_w_i;  off_o = fd_o_i;  end
            RATE_XL: begin width_o = xl_w_i;  off_o = xl_o_i;  end
            default: begin width_o = nom_w_i; off_o = nom_o_i; end
        endcase
    end
endmodule

// File: rtl/cbt_run_cnt.sv
module cbt_run_cnt #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic stb_i,
    input  logic bit_i,
    output logic full_o
);
    localparam int RUN_W = $clog2(IDLE_BITS + 1);
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run <= '0;
        else if (clr_i)  run <= '0;
        else if (stb_i) begin
            if (!bit_i)  run <= '0;
            else if (run != RUN_W'(IDLE_BITS)) run <= run + 1'b1;
        end
    end

    assign full_o = stb_i & bit_i & (run == RUN_W'(IDLE_BITS - 1));
endmodule

// File: rtl/can_rate_timer.sv
module can_rate_timer
    import can_bt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int GUARD     = 2,
    parameter int IDLE_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic [CNT_W-1:0] nom_width_i,
    input  logic [CNT_W-1:0] nom_samp_i,
    input  logic [CNT_W-1:0] fd_width_i,
    input  logic [CNT_W-1:0] fd_samp_i,
    input  logic [CNT_W-1:0] xl_width_i,
    input  logic [CNT_W-1:0] xl_samp_i,
    input  logic             req_nom_i,
    input  logic             req_fd_i,
    input  logic             req_xl_i,
    output logic             smp_stb_o,
    output logic             smp_bit_o,
    output logic [1:0]       rate_o
);
    localparam int CW1 = CNT_W + 1;

    bt_state_e        state;
    rate_e            rate, next_rate;
    logic [CNT_W-1:0] cnt, tail_len;
    logic             resynced;
    logic             fall, stb, idle_full, resync_ok;
    logic             lead_guard, tail_guard;
    logic [CNT_W-1:0] cur_w, cur_o, new_w, new_o;

    cbt_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .fall_o(fall)
    );

    cbt_rate_sel #(.CNT_W(CNT_W)) u_cur_sel (
        .rate_i(rate),
        .nom_w_i(nom_width_i), .nom_o_i(nom_samp_i),
        .fd_w_i(fd_width_i),   .fd_o_i(fd_samp_i),
        .xl_w_i(xl_width_i),   .xl_o_i(xl_samp_i),
        .width_o(cur_w), .off_o(cur_o)
    );

    cbt_rate_sel #(.CNT_W(CNT_W)) u_new_sel (
        .rate_i(next_rate),
        .nom_w_i(nom_width_i), .nom_o_i(nom_samp_i),
        .fd_w_i(fd_width_i),   .fd_o_i(fd_samp_i),
        .xl_w_i(xl_width_i),   .xl_o_i(xl_samp_i),
        .width_o(new_w), .off_o(new_o)
    );

    cbt_run_cnt #(.IDLE_BITS(IDLE_BITS)) u_run (
        .clk(clk), .rst_n(rst_n), .clr_i(state == ST_IDLE),
        .stb_i(stb), .bit_i(rx_i), .full_o(idle_full)
    );

    // Sample instant and request arbitration
    assign stb = (state == ST_LEAD) && (cnt == cur_o);

    always_comb begin
        if (req_nom_i)     next_rate = RATE_NOM;
        else if (req_xl_i) next_rate = RATE_XL;
        else if (req_fd_i) next_rate = RATE_FD;
        else               next_rate = rate;
    end

    // Guard band around the strobe and one-per-bit resync rule
    assign lead_guard = (CW1'(cnt) + CW1'(GUARD)) >= CW1'(cur_o);
    assign tail_guard = cnt <= CNT_W'(GUARD);
    assign resync_ok  = fall && !resynced &&
                        ((state == ST_LEAD) ? !lead_guard : !tail_guard);

    // State register and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rate     <= RATE_NOM;
            cnt      <= '0;
            tail_len <= '0;
            resynced <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (fall) begin
                        state    <= ST_LEAD;
                        cnt      <= CNT_W'(1);
                        resynced <= 1'b1;
                        rate     <= RATE_NOM;
                    end
                end
                ST_LEAD: begin
                    if (stb) begin
                        if (idle_full) begin
                            state <= ST_IDLE;
                            rate  <= RATE_NOM;
                        end else begin
                            state    <= ST_TAIL;
                            cnt      <= CNT_W'(1);
                            rate     <= next_rate;
                            tail_len <= new_w - new_o;
                        end
                    end else if (resync_ok) begin
                        cnt      <= CNT_W'(1);
                        resynced <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (resync_ok) begin
                        state    <= ST_LEAD;
                        cnt      <= CNT_W'(1);
                        resynced <= 1'b1;
                    end else if (cnt == tail_len - 1'b1) begin
                        state    <= ST_LEAD;
                        cnt      <= '0;
                        resynced <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        smp_stb_o = stb;
        smp_bit_o = stb ? rx_i : 1'b1;
        rate_o    = rate;
    end

    logic unused_w;
    assign unused_w = ^cur_w;
endmodule

// File: rtl/can_rate_timer_chk.sv
module can_rate_timer_chk
    import can_bt_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      smp_stb_o,
    input logic [1:0] rate_o,
    input logic      req_nom_i,
    input logic      req_xl_i,
    input bt_state_e state,
    input logic      fall
);
    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb_o |=> !smp_stb_o);

    p_rate_at_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_o) |-> $past(smp_stb_o));

    p_prio_xl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb_o && req_xl_i && !req_nom_i) |=> (rate_o == 2'd2 || state == ST_IDLE));

    p_back_nom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb_o && req_nom_i) |=> (rate_o == 2'd0));

    p_hard_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fall) |=> (state == ST_LEAD));

    p_idle_nom_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (rate_o == 2'd0 && !smp_stb_o));
endmodule

bind can_rate_timer can_rate_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smp_stb_o(smp_stb_o), .rate_o(rate_o),
    .req_nom_i(req_nom_i), .req_xl_i(req_xl_i), .state(state), .fall(fall)
);

// File: tb/sim_can_rate_timer.sv
`timescale 1ns/1ps
module sim_can_rate_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       rq_nom = 1'b0, rq_fd = 1'b0, rq_xl = 1'b0;
    logic       smp_stb, smp_bit;
    logic [1:0] rate;

    int tick = 0;
    int n_chk = 0, n_fail = 0;
    int ns = 0;
    int st [0:511];
    logic sb [0:511];

    always #2 clk = ~clk;   // 250 MHz

    can_rate_timer u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx),
        .nom_width_i(8'd20), .nom_samp_i(8'd14),
        .fd_width_i(8'd10),  .fd_samp_i(8'd7),
        .xl_width_i(8'd6),   .xl_samp_i(8'd4),
        .req_nom_i(rq_nom), .req_fd_i(rq_fd), .req_xl_i(rq_xl),
        .smp_stb_o(smp_stb), .smp_bit_o(smp_bit), .rate_o(rate)
    );

    always @(posedge clk) tick <= tick + 1;

    always @(negedge clk) begin
        if (smp_stb) begin
            if (ns < 512) begin st[ns] = tick; sb[ns] = smp_bit; end
            ns = ns + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic at_tick(input int x);
        while (tick < x) begin @(posedge clk); #1; end
    endtask

    task automatic sof(output int t, output int b);
        @(posedge clk); #1;
        t = tick; b = ns; rx = 1'b0;
    endtask

    task automatic return_idle();
        int q = 0;
        @(posedge clk); #1; rx = 1'b1;
        while (q < 80) begin
            @(negedge clk);
            if (smp_stb) q = 0; else q++;
        end
    endtask

    task automatic t_reset();
        int b = ns;
        repeat (60) @(posedge clk);
        #1;
        chk("R1 rate after reset", rate, 0);
        chk("R1 no strobe in idle", ns - b, 0);
    endtask

    task automatic t_nominal_idle();
        int t, b;
        sof(t, b);
        at_tick(t + 40); rx = 1'b1;
        at_tick(t + 350);
        chk("R2 first strobe", st[b], t + 14);
        chk("R2 second strobe", st[b+1], t + 34);
        chk("R3 dominant sample", sb[b+1], 0);
        chk("R3 recessive sample", sb[b+2], 1);
        chk("R3 strobe count", ns - b, 13);
        chk("R11 last strobe before idle", st[b+12], t + 254);
        chk("R11 rate in idle", rate, 0);
    endtask

    task automatic t_fd_switch();
        int t, b;
        sof(t, b);
        at_tick(t + 15); rq_fd = 1'b1;
        at_tick(t + 35); rq_fd = 1'b0;
        chk("R4 FD rate after strobe", rate, 1);
        at_tick(t + 55); rq_nom = 1'b1;
        at_tick(t + 65); rq_nom = 1'b0;
        chk("R7 nominal rate back", rate, 0);
        at_tick(t + 110);
        chk("R5 hybrid bit into FD", st[b+2], t + 44);
        chk("R6 FD spacing", st[b+3] - st[b+2], 10);
        chk("R6 FD spacing 2", st[b+4], t + 64);
        chk("R7 hybrid bit back", st[b+5], t + 84);
        chk("R7 nominal spacing", st[b+6], t + 104);
        return_idle();
    endtask

    task automatic t_xl_prio();
        int t, b;
        sof(t, b);
        at_tick(t + 20); rq_fd = 1'b1;
        at_tick(t + 21); rq_fd = 1'b0;
        at_tick(t + 22);
        chk("R4 request off strobe ignored", rate, 0);
        at_tick(t + 50); rq_fd = 1'b1; rq_xl = 1'b1;
        at_tick(t + 55); rq_fd = 1'b0; rq_xl = 1'b0;
        chk("R4 XL over FD", rate, 2);
        at_tick(t + 63); rq_nom = 1'b1; rq_xl = 1'b1;
        at_tick(t + 67); rq_nom = 1'b0; rq_xl = 1'b0;
        chk("R4 nominal over XL", rate, 0);
        at_tick(t + 90);
        chk("R4 timing unchanged by stray request", st[b+1], t + 34);
        chk("R5 hybrid bit into XL", st[b+3], t + 60);
        chk("R6 XL spacing", st[b+4], t + 66);
        chk("R7 hybrid XL to nominal", st[b+5], t + 86);
        return_idle();
    endtask

    task automatic t_resync();
        int t, b;
        sof(t, b);
        at_tick(t + 22); rx = 1'b1;
        at_tick(t + 25); rx = 1'b0;
        at_tick(t + 28); rx = 1'b1;
        at_tick(t + 31); rx = 1'b0;
        at_tick(t + 47); rx = 1'b1;
        at_tick(t + 50); rx = 1'b0;
        at_tick(t + 70);
        chk("R8 re-anchored strobe", st[b+1], t + 39);
        chk("R8 sample after resync", sb[b+1], 0);
        chk("R9 second edge ignored", st[b+2], t + 64);
        return_idle();
    endtask

    task automatic t_guard();
        int t, b;
        sof(t, b);
        at_tick(t + 25); rx = 1'b1;
        at_tick(t + 32); rx = 1'b0;
        at_tick(t + 44); rx = 1'b1;
        at_tick(t + 56); rx = 1'b0;
        at_tick(t + 82); rx = 1'b1;
        at_tick(t + 91); rx = 1'b0;
        at_tick(t + 110);
        chk("R10 edge before strobe ignored", st[b+1], t + 34);
        chk("R10 recessive sample", sb[b+2], 1);
        chk("R10 edge after strobe ignored", st[b+3], t + 74);
        chk("R8 edge outside guard taken", st[b+4], t + 105);
        return_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 no strobe in reset", smp_stb, 0);
        rst_n = 1'b1;
        t_reset();
        t_nominal_idle();
        t_fd_switch();
        t_xl_prio();
        t_resync();
        t_guard();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule